// File: doc/BRIEF.md
# Masked Receiver Reset Sequencer

This block generates the internal reset lines of a serial receiver datapath: eight lines for the analog-side circuits and four for the digital-side logic. A run starts when the master reset input falls. At that edge the block captures a 12-bit selection, made of an 8-bit analog mask and a 4-bit digital mask, together with a 2-bit mode. It then either walks through the selected lines one at a time or pulses all of them together. When the last selected line is released, it issues a one-cycle done pulse.

In sequential mode, a digital-side line is not released until the user-ready input has been seen High during the run. This lets the clock domain behind that logic settle before it leaves reset. Twelve direct inputs each drive exactly one line and bypass the masks entirely. These direct inputs are meant for idle periods, so the block flags misuse: a direct input driven during a run sets an error flag, and so does a change to the captured mask or mode inputs.

Top module: `rxrst_seq`

## Requirements
- R1: A run starts when `master_rst_i` is sampled Low on a rising edge after being sampled High on the previous edge, and the block is idle. If any mask bit is set, the first selected line is High in the cycle after that edge.
- R2: `mode_i` equal to 2'b00 selects sequential mode, and every other value selects simultaneous mode. The mode and both masks are captured at the start edge.
- R3: In sequential mode, exactly one mask-driven line is High at a time. The order is analog bits 0 to 7 (line positions 0 to 7), then digital bits 0 to 3 (positions 8 to 11). Unselected lines are skipped, and each line follows the previous one with no gap.
- R4: Each mask-driven line stays High for exactly HOLD_CYC cycles (default 8) unless R6 extends it.
- R5: In simultaneous mode, all selected lines rise in the same cycle and fall in the same cycle, after HOLD_CYC cycles.
- R6: In sequential mode, a digital-side line falls only on an edge at or after the first edge on which `user_rdy_i` is sampled High during the run. In simultaneous mode, `user_rdy_i` has no effect.
- R7: Bit k of `direct_rst_i` drives line position k High in the same cycle, whatever the masks, mode or state. It touches no other line.
- R8: A change of `mode_i`, `ana_mask_i` or `dig_mask_i` during a run sets `err_o` in the next cycle. `err_o` stays set until the next run starts.
- R9: Any `direct_rst_i` bit High during a run sets `err_o` in the next cycle.
- R10: `done_o` is High for exactly one cycle: the first cycle in which the last selected line is Low.
- R11: A run with both masks zero asserts no line and raises `done_o` in the cycle after the start edge.
- R12: A falling edge of `master_rst_i` during a run does not alter that run.
- R13: After reset, all reset lines, `done_o` and `err_o` are Low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_rst_i | input | 1 | Master reset; a falling edge starts a run |
| mode_i | input | 2 | 2'b00 sequential, otherwise simultaneous |
| ana_mask_i | input | 8 | Analog-side line selection |
| dig_mask_i | input | 4 | Digital-side line selection |
| user_rdy_i | input | 1 | Permits release of digital-side lines in sequential mode |
| direct_rst_i | input | 12 | Per-line direct resets, bits 0-7 analog, 8-11 digital |
| ana_rst_o | output | 8 | Analog-side reset lines |
| dig_rst_o | output | 4 | Digital-side reset lines |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky rule-violation flag |

## Verification
A master falling edge can arrive in the same cycle as an ongoing sequential release, and a direct reset can be active in the same cycle as a mask-driven line. The bench provokes the first by toggling `master_rst_i` in the middle of a sequential walk. It then expects the scoreboard's timeline of line changes to be unchanged. It provokes the second by raising a digital direct bit while an analog line is in its hold. It then requires both lines High in that cycle and `err_o` set in the next.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } rxrst_state_e;

   localparam logic [1:0] MODE_SEQUENTIAL = 2'b00;
endpackage

// File: rtl/rxrst_edge.sv
module rxrst_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/rxrst_pick.sv
module rxrst_pick #(
   parameter int N     = 12,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     sel_i,
   input  logic [IDX_W-1:0] cur_i,
   input  logic             from_start_i,
   output logic [IDX_W-1:0] nxt_o,
   output logic             found_o
);
   always_comb begin
      logic hit;
      hit   = 1'b0;
      nxt_o = '0;
      for (int i = 0; i < N; i++) begin
         if (!hit && sel_i[i] && (from_start_i || (IDX_W'(i) > cur_i))) begin
            hit   = 1'b1;
            nxt_o = IDX_W'(i);
         end
      end
      found_o = hit;
   end
endmodule

// File: rtl/rxrst_drive.sv
module rxrst_drive #(
   parameter int N     = 12,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             busy_i,
   input  logic             seq_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [N-1:0]     sel_i,
   input  logic [N-1:0]     direct_i,
   output logic [N-1:0]     drv_o,
   output logic [N-1:0]     line_o
);
   for (genvar g = 0; g < N; g++) begin : g_line
      logic in_seq;
      logic in_sim;
      assign in_seq    = seq_i && (idx_i == IDX_W'(g));
      assign in_sim    = !seq_i && sel_i[g];
      assign drv_o[g]  = busy_i && (in_seq || in_sim);
      assign line_o[g] = drv_o[g] | direct_i[g];
   end
endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
   import rxrst_pkg::*;
#(
   parameter int NUM_ANA  = 8,
   parameter int NUM_DIG  = 4,
   parameter int HOLD_CYC = 8,
   parameter int MODE_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       master_rst_i,
   input  logic [MODE_W-1:0]          mode_i,
   input  logic [NUM_ANA-1:0]         ana_mask_i,
   input  logic [NUM_DIG-1:0]         dig_mask_i,
   input  logic                       user_rdy_i,
   input  logic [NUM_ANA+NUM_DIG-1:0] direct_rst_i,
   output logic [NUM_ANA-1:0]         ana_rst_o,
   output logic [NUM_DIG-1:0]         dig_rst_o,
   output logic                       done_o,
   output logic                       err_o
);
   localparam int NLINE = NUM_ANA + NUM_DIG;
   localparam int IDX_W = (NLINE > 1) ? $clog2(NLINE) : 1;
   localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);
   localparam logic [IDX_W-1:0] FIRST_DIG = IDX_W'(NUM_ANA);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("rxrst_seq: HOLD_CYC must be at least 1");
   end
   if (NUM_ANA < 1 || NUM_DIG < 1) begin : g_bad_count
      $error("rxrst_seq: both line groups need at least one line");
   end
   if (MODE_W < 2) begin : g_bad_mode
      $error("rxrst_seq: MODE_W must be at least 2");
   end

   rxrst_state_e        state_q;
   logic [IDX_W-1:0]    idx_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                seq_q;
   logic [NLINE-1:0]    sel_q;
   logic [MODE_W-1:0]   mode_q;
   logic                rdy_q;
   logic                done_q;
   logic                err_q;

   logic                fall;
   logic                start;
   logic                busy;
   logic [NLINE-1:0]    sel_in;
   logic [NLINE-1:0]    pick_sel;
   logic [IDX_W-1:0]    nxt_idx;
   logic                nxt_found;
   logic                hold_done;
   logic                rdy_ok;
   logic                release_now;
   logic                cfg_moved;
   logic                viol;
   logic [NLINE-1:0]    drv;
   logic [NLINE-1:0]    lines;

   rxrst_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (master_rst_i),
      .fall_o (fall)
   );

   assign busy     = (state_q == ST_RUN);
   assign start    = fall && !busy;
   assign sel_in   = {dig_mask_i, ana_mask_i};
   assign pick_sel = start ? sel_in : sel_q;

   rxrst_pick #(.N(NLINE), .IDX_W(IDX_W)) u_pick (
      .sel_i        (pick_sel),
      .cur_i        (idx_q),
      .from_start_i (start),
      .nxt_o        (nxt_idx),
      .found_o      (nxt_found)
   );

   assign hold_done   = (cnt_q == CNT_LAST);
   assign rdy_ok      = !seq_q || (idx_q < FIRST_DIG) || rdy_q || user_rdy_i;
   assign release_now = busy && hold_done && rdy_ok;
   assign cfg_moved   = (sel_in != sel_q) || (mode_i != mode_q);
   assign viol        = cfg_moved || (|direct_rst_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         cnt_q   <= '0;
         seq_q   <= 1'b1;
         sel_q   <= '0;
         mode_q  <= '0;
         rdy_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            sel_q  <= sel_in;
            mode_q <= mode_i;
            seq_q  <= (mode_i[1:0] == MODE_SEQUENTIAL) && (mode_i >> 2 == '0);
            rdy_q  <= user_rdy_i;
            err_q  <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= nxt_idx;
            if (|sel_in) state_q <= ST_RUN;
            else         done_q  <= 1'b1;
         end else if (busy) begin
            rdy_q <= rdy_q | user_rdy_i;
            err_q <= err_q | viol;
            if (release_now) begin
               cnt_q <= '0;
               if (seq_q && nxt_found) begin
                  idx_q <= nxt_idx;
               end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end else if (!hold_done) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   rxrst_drive #(.N(NLINE), .IDX_W(IDX_W)) u_drive (
      .busy_i   (busy),
      .seq_i    (seq_q),
      .idx_i    (idx_q),
      .sel_i    (sel_q),
      .direct_i (direct_rst_i),
      .drv_o    (drv),
      .line_o   (lines)
   );

   assign ana_rst_o = lines[NUM_ANA-1:0];
   assign dig_rst_o = lines[NLINE-1:NUM_ANA];
   assign done_o    = done_q;
   assign err_o     = err_q;

   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (|sel_in)) |=> (|drv));

   assert_onehot_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && seq_q) |-> $onehot(drv));

   assert_sim_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seq_q) |-> (drv == sel_q));

   assert_dig_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && seq_q && (idx_q >= FIRST_DIG) && !rdy_q && !user_rdy_i)
      |=> (busy && $stable(idx_q)));

   assert_cfg_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_moved) |=> err_o);

   assert_direct_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (|direct_rst_i)) |=> err_o);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (drv == '0));

   assert_empty_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (sel_in == '0)) |=> (done_o && !busy));

   assert_ignore_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fall && !release_now) |=> (busy && $stable(sel_q)));
endmodule

// File: tb/rxrst_seq_tb.sv
`timescale 1ns/1ps
module rxrst_seq_tb;
   localparam int HOLD = 8;

   typedef struct {
      logic [11:0] lines;
      logic        done;
      int          at;
      string       req;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_rst = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  ana_mask = '0;
   logic [3:0]  dig_mask = '0;
   logic        user_rdy = 1'b1;
   logic [11:0] direct = '0;
   logic [7:0]  ana_rst;
   logic [3:0]  dig_rst;
   logic        done;
   logic        err;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc = 0;
   bit mon_en = 1'b0;
   sb_item_t exp_q[$];
   logic [12:0] last_obs = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rxrst_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .master_rst_i (master_rst),
      .mode_i       (mode),
      .ana_mask_i   (ana_mask),
      .dig_mask_i   (dig_mask),
      .user_rdy_i   (user_rdy),
      .direct_rst_i (direct),
      .ana_rst_o    (ana_rst),
      .dig_rst_o    (dig_rst),
      .done_o       (done),
      .err_o        (err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)",
                  req, what, act, exp, cyc);
      end
   endtask

   // monitor: every change of {done, lines} must match the next queued item
   always @(negedge clk) begin
      logic [12:0] obs;
      obs = {done, dig_rst, ana_rst};
      if (mon_en && obs != last_obs) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected output change", int'(obs), int'(last_obs));
         end else begin
            sb_item_t it;
            it = exp_q.pop_front();
            chk(obs == {it.done, it.lines}, it.req, "line/done value",
                int'(obs), int'({it.done, it.lines}));
            chk(cyc == it.at, it.req, "change cycle", cyc, it.at);
         end
      end
      last_obs = obs;
   end

   task automatic push(input logic [11:0] l, input logic d, input int t, input string r);
      sb_item_t it;
      it.lines = l; it.done = d; it.at = t; it.req = r;
      exp_q.push_back(it);
   endtask

   // returns the cycle number in which the block is first seen running
   task automatic kick(output int c0);
      @(negedge clk); master_rst = 1'b1;
      @(negedge clk); master_rst = 1'b0;
      c0 = cyc + 1;
   endtask

   // driver: computes the expected timeline from the requirements
   task automatic run_case(input logic [1:0] md, input logic [7:0] am,
                           input logic [3:0] dm, input int rdy_off,
                           input bit poke, input string tag);
      int c0, t, rdy_at;
      logic [11:0] sel;
      @(negedge clk);
      mode = md; ana_mask = am; dig_mask = dm;
      user_rdy = (rdy_off < 0);
      sel = {dm, am};
      mon_en = 1'b1;
      kick(c0);
      rdy_at = (rdy_off < 0) ? 0 : c0 + rdy_off + 1;
      t = c0;
      if (md == 2'b00) begin
         for (int i = 0; i < 12; i++) begin
            if (sel[i]) begin
               int rel;
               push(12'(1) << i, 1'b0, t, tag);
               rel = t + HOLD;
               if (i >= 8 && rdy_at > rel) rel = rdy_at;
               t = rel;
            end
         end
      end else if (sel != '0) begin
         push(sel, 1'b0, t, tag);
         t = t + HOLD;
      end
      push('0, 1'b1, t, "R10");
      push('0, 1'b0, t + 1, "R10");
      while (exp_q.size() != 0) begin
         @(negedge clk);
         if (rdy_off >= 0 && cyc == c0 + rdy_off) user_rdy = 1'b1;
         if (poke && cyc == c0 + 20) master_rst = 1'b1;
         if (poke && cyc == c0 + 21) master_rst = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, tag, "scoreboard drained", exp_q.size(), 0);
      mon_en = 1'b0;
      user_rdy = 1'b1;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      chk({ana_rst, dig_rst, done, err} == '0, "R13", "outputs in reset",
          int'({ana_rst, dig_rst, done, err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({ana_rst, dig_rst, done, err} == '0, "R13", "outputs after reset",
          int'({ana_rst, dig_rst, done, err}), 0);

      // R1 R3 R4: full sequential walk
      run_case(2'b00, 8'hFF, 4'hF, -1, 1'b0, "R3");
      // R3: sparse selection, skips unselected lines
      run_case(2'b00, 8'b1010_0100, 4'b0101, -1, 1'b0, "R3");
      // R5 R2: simultaneous with two nonzero codes
      run_case(2'b01, 8'hF0, 4'hF, -1, 1'b0, "R5");
      run_case(2'b11, 8'h81, 4'h0, -1, 1'b0, "R2");
      // R11: nothing selected
      run_case(2'b00, 8'h00, 4'h0, -1, 1'b0, "R11");
      // R6: late ready stretches the digital line
      run_case(2'b00, 8'h01, 4'b0010, 30, 1'b0, "R6");
      // R6: ready is not consulted in simultaneous mode
      run_case(2'b10, 8'h00, 4'hF, 50, 1'b0, "R6");
      // R12: master toggled mid-run
      run_case(2'b00, 8'hFF, 4'hF, -1, 1'b1, "R12");
      // digital-only reset (analog mask zero)
      run_case(2'b00, 8'h00, 4'hF, -1, 1'b0, "R4");

      // R7: direct lines while idle
      @(negedge clk); direct = 12'h010;
      #1 chk(ana_rst == 8'h10 && dig_rst == 4'h0, "R7", "direct analog bit 4",
             int'({dig_rst, ana_rst}), 12'h010);
      @(negedge clk); direct = 12'h400;
      #1 chk(ana_rst == 8'h00 && dig_rst == 4'b0100, "R7", "direct digital bit 10",
             int'({dig_rst, ana_rst}), 12'h400);
      @(negedge clk); direct = '0;
      chk(err == 1'b0, "R7", "no error while idle", int'(err), 0);

      // R8: mask change during a run
      mode = 2'b00; ana_mask = 8'hFF; dig_mask = 4'h0;
      kick(c0);
      while (cyc != c0 + 5) @(negedge clk);
      ana_mask = 8'h0F;
      @(negedge clk);
      chk(err == 1'b1, "R8", "err after mask change", int'(err), 1);
      wait_done();
      chk(err == 1'b1, "R8", "err sticky after done", int'(err), 1);
      ana_mask = 8'h03;
      kick(c0);
      @(negedge clk);
      chk(err == 1'b0, "R8", "err cleared by new run", int'(err), 0);

      // R9 and R7 together: direct bit during the run above
      while (cyc != c0 + 2) @(negedge clk);
      direct = 12'h800;
      #1 chk(dig_rst == 4'b1000 && ana_rst == 8'h01, "R7", "direct with mask line",
             int'({dig_rst, ana_rst}), 12'h801);
      @(negedge clk);
      chk(err == 1'b1, "R9", "err after direct in run", int'(err), 1);
      direct = '0;
      wait_done();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule